// File: doc/BRIEF.md
# Dual-Channel Input Capture Unit

This unit timestamps external events for a pair of channels. Each channel watches one pin. When the edge that its edge-select field asks for arrives, the channel copies the current value of an external 16-bit free-running counter into its capture register. At the same time it sets a detection flag. When that channel's interrupt enable is also set, the flag drives the channel's interrupt output.

Both channels share one 8-bit control/status register that holds their flags, interrupt enables and edge selects. Software reads and writes that register through a small bus port, and reads the two capture registers through the same port. A flag clears only when software writes 0 to it; writing 1 leaves it as it was. Each pin passes through a two-flop synchronizer before edge detection.

Top module: `capture_pair`

## Requirements
- R1: After reset the control register reads 0x00, both capture registers read 0x0000, and both interrupt outputs are low.
- R2: Address 0 reads the control register, zero-extended. Address 1 reads the lower-channel capture register and address 2 reads the upper-channel capture register. In the control register, bit 7 is the upper flag and bit 6 is the lower flag. Bit 5 is the upper enable and bit 4 is the lower enable. Bits 3:2 are the upper edge select and bits 1:0 are the lower edge select. Bits 5:0 read back as written.
- R3: Edge select 01 detects rising edges of the pin only.
- R4: Edge select 10 detects falling edges of the pin only.
- R5: Edge select 11 detects both rising and falling edges.
- R6: With edge select 00 a channel sets no flag and captures nothing, whatever its pin does.
- R7: On a detected edge, the flag and the capture register update on the same rising clock edge, the third one after the pin changes. The capture register takes the counter value present at that edge.
- R8: A control write with 0 in a flag bit clears that flag, and a write with 1 there leaves the flag unchanged.
- R9: A channel's interrupt output is high exactly when both its flag and its enable are 1.
- R10: If a detected edge and a write of 0 to the same flag fall on the same clock edge, the flag ends up set.
- R11: Bus writes to the capture register addresses have no effect.
- R12: An event on one channel changes neither the flag nor the capture register of the other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data (bits 7:0 used for control) |
| bus_rdata | output | 16 | Read data for bus_addr |
| pin_lo | input | 1 | Lower-channel event pin |
| pin_hi | input | 1 | Upper-channel event pin |
| cnt_val | input | 16 | Free-running counter value |
| irq_lo | output | 1 | Lower-channel interrupt request |
| irq_hi | output | 1 | Upper-channel interrupt request |

## Verification
Two things can land on the same clock edge: the hardware setting a flag after a detected edge, and software writing 0 to that same flag. The bench provokes this by setting the flag once and then raising the pin again. It counts the synchronizer stages and times a control write with flag bit 0 so that the write is sampled on exactly the edge at which detection lands. The flag must then read 1 and the capture register must hold the new counter value. A separate clear with no edge present confirms that the write path itself works.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int CTRL_W      = 8;
  localparam int FLAG_HI_BIT = 7;
  localparam int FLAG_LO_BIT = 6;
  localparam int EN_HI_BIT   = 5;
  localparam int EN_LO_BIT   = 4;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_CAP_LO = 2'd1;
  localparam logic [1:0] ADDR_CAP_HI = 2'd2;
endpackage

// File: rtl/cap_rst_sync.sv
module cap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  edge_sel_e        edge_sel,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             det,
  output logic [CNT_W-1:0] cap_val
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;
  logic                   pin_s;
  logic                   rise, fall;
  logic [CNT_W-1:0]       cap_q, cap_d;

  assign pin_s = sync_q[SYNC_STAGES-1];

  // synchronizer shift
  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin};
  end

  // edge classification
  always_comb begin
    rise = pin_s & ~prev_q;
    fall = ~pin_s & prev_q;
    unique case (edge_sel)
      EDGE_RISE: det = rise;
      EDGE_FALL: det = fall;
      EDGE_BOTH: det = rise | fall;
      default:   det = 1'b0;
    endcase
  end

  // capture next state with explicit load enable
  always_comb begin
    cap_d = cap_q;
    if (det) cap_d = cnt_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= pin_s;
      cap_q  <= cap_d;
    end
  end

  assign cap_val = cap_q;
endmodule

// File: rtl/cap_ctrl_reg.sv
module cap_ctrl_reg
  import cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic [1:0]        det,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CTRL_W-1:0] ctrl_d;
  logic              keep_lo, keep_hi;

  always_comb begin
    // a written 0 drops the flag, a written 1 keeps it
    keep_lo = ~(wr_en & ~wdata[FLAG_LO_BIT]);
    keep_hi = ~(wr_en & ~wdata[FLAG_HI_BIT]);
    ctrl_d  = ctrl_q;
    if (wr_en) ctrl_d[EN_HI_BIT:0] = wdata[EN_HI_BIT:0];
    // hardware set is ORed last so it wins over a same-cycle clear
    ctrl_d[FLAG_LO_BIT] = (ctrl_q[FLAG_LO_BIT] & keep_lo) | det[0];
    ctrl_d[FLAG_HI_BIT] = (ctrl_q[FLAG_HI_BIT] & keep_hi) | det[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/capture_pair.sv
module capture_pair
  import cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             pin_lo,
  input  logic             pin_hi,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             irq_lo,
  output logic             irq_hi
);
  localparam int NCH = 2;

  logic                       rst_n_s;
  logic [NCH-1:0]             pins;
  logic [NCH-1:0]             det;
  logic [NCH-1:0][CNT_W-1:0]  cap_q;
  logic [CTRL_W-1:0]          ctrl_q;
  logic                       wr_ctrl;
  logic                       unused_wdata;

  assign pins         = {pin_hi, pin_lo};
  assign wr_ctrl      = bus_wr && (bus_addr == ADDR_CTRL);
  assign unused_wdata = ^bus_wdata[CNT_W-1:CTRL_W];

  cap_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cap_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .pin      (pins[c]),
      .edge_sel (edge_sel_e'(ctrl_q[2*c +: 2])),
      .cnt_val  (cnt_val),
      .det      (det[c]),
      .cap_val  (cap_q[c])
    );
  end

  cap_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_en  (wr_ctrl),
    .wdata  (bus_wdata[CTRL_W-1:0]),
    .det    (det),
    .ctrl_q (ctrl_q)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL:   bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      ADDR_CAP_LO: bus_rdata = cap_q[0];
      ADDR_CAP_HI: bus_rdata = cap_q[1];
      default:     bus_rdata = '0;
    endcase
  end

  assign irq_lo = ctrl_q[FLAG_LO_BIT] & ctrl_q[EN_LO_BIT];
  assign irq_hi = ctrl_q[FLAG_HI_BIT] & ctrl_q[EN_HI_BIT];
endmodule

// File: rtl/capture_pair_chk.sv
module capture_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic [15:0] cnt_val,
  input logic        irq_hi,
  input logic [7:0]  ctrl,
  input logic [1:0]  det,
  input logic [15:0] cap_lo,
  input logic [15:0] cap_hi
);
  // R6
  off_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1:0] == 2'b00) |-> !det[0]);

  // R7
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det[0] |=> (cap_lo == $past(cnt_val)));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && !(bus_wr && bus_addr == 2'd0 && !bus_wdata[6])) |=> ctrl[6]);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det[1] |=> ctrl[7]);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (ctrl[7] && ctrl[5]));

  // R11
  cap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det[1] |=> $stable(cap_hi));
endmodule

bind capture_pair capture_pair_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cnt_val   (cnt_val),
  .irq_hi    (irq_hi),
  .ctrl      (ctrl_q),
  .det       (det),
  .cap_lo    (cap_q[0]),
  .cap_hi    (cap_q[1])
);

// File: tb/capture_pair_test.sv
module capture_pair_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        pin_lo, pin_hi;
  logic [15:0] cnt_val;
  logic        irq_lo, irq_hi;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_pair uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_lo(pin_lo),
    .pin_hi(pin_hi), .cnt_val(cnt_val), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    bus_read(2'd0, v); check("R1 ctrl", v, 16'h0000);
    bus_read(2'd1, v); check("R1 cap_lo", v, 16'h0000);
    bus_read(2'd2, v); check("R1 cap_hi", v, 16'h0000);
    check("R1 irqs", {14'd0, irq_hi, irq_lo}, 16'h0000);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    bus_write(2'd0, 16'h00FF);
    bus_read(2'd0, v); check("R2 readback, R8 flag write 1", v, 16'h003F);
    bus_write(2'd0, 16'h0024);
    bus_read(2'd0, v); check("R2 readback", v, 16'h0024);
    bus_write(2'd0, 16'h0000);
  endtask

  task automatic t_rise();
    logic [15:0] v;
    bus_write(2'd0, 16'h0001);
    cnt_val = 16'h1234;
    pin_lo = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_read(2'd0, v); check("R7 not yet set", v & 16'h0040, 16'h0000);
    @(negedge clk);
    bus_read(2'd0, v); check("R7 third edge, R3 rise", v & 16'h0040, 16'h0040);
    bus_read(2'd1, v); check("R7 capture", v, 16'h1234);
    check("R9 no irq without enable", {15'd0, irq_lo}, 16'h0000);
    bus_write(2'd0, 16'h0001);
    bus_read(2'd0, v); check("R8 clear", v & 16'h0040, 16'h0000);
    cnt_val = 16'h5555;
    pin_lo = 1'b0; settle();
    bus_read(2'd0, v); check("R3 fall ignored", v & 16'h0040, 16'h0000);
    bus_read(2'd1, v); check("R3 cap kept", v, 16'h1234);
  endtask

  task automatic t_fall();
    logic [15:0] v;
    bus_write(2'd0, 16'h0008);
    cnt_val = 16'h1111; pin_hi = 1'b1; settle();
    bus_read(2'd0, v); check("R4 rise ignored", v & 16'h0080, 16'h0000);
    cnt_val = 16'h2222; pin_hi = 1'b0; settle();
    bus_read(2'd0, v); check("R4 fall flag", v & 16'h00C0, 16'h0080);
    bus_read(2'd2, v); check("R4 cap_hi", v, 16'h2222);
    bus_read(2'd1, v); check("R12 cap_lo untouched", v, 16'h1234);
    bus_write(2'd0, 16'h0000);
  endtask

  task automatic t_both();
    logic [15:0] v;
    bus_write(2'd0, 16'h0013);
    cnt_val = 16'h0A0A; pin_lo = 1'b1; settle();
    bus_read(2'd1, v); check("R5 rise cap", v, 16'h0A0A);
    check("R9 irq_lo high", {15'd0, irq_lo}, 16'h0001);
    check("R12 irq_hi low", {15'd0, irq_hi}, 16'h0000);
    bus_write(2'd0, 16'h0053);
    bus_read(2'd0, v); check("R8 write 1 keeps", v & 16'h0040, 16'h0040);
    cnt_val = 16'h0B0B; pin_lo = 1'b0; settle();
    bus_read(2'd1, v); check("R5 fall cap", v, 16'h0B0B);
    bus_write(2'd0, 16'h0013);
    check("R9 irq_lo drops", {15'd0, irq_lo}, 16'h0000);
    bus_write(2'd0, 16'h0000);
  endtask

  task automatic t_off();
    logic [15:0] v;
    cnt_val = 16'h7777;
    pin_lo = 1'b1; pin_hi = 1'b1; settle();
    pin_lo = 1'b0; pin_hi = 1'b0; settle();
    bus_read(2'd0, v); check("R6 no flags", v, 16'h0000);
    bus_read(2'd1, v); check("R6 cap_lo", v, 16'h0B0B);
    bus_read(2'd2, v); check("R6 cap_hi", v, 16'h2222);
  endtask

  task automatic t_capwr();
    logic [15:0] v;
    bus_write(2'd1, 16'hFFFF);
    bus_write(2'd2, 16'hFFFF);
    bus_read(2'd1, v); check("R11 cap_lo", v, 16'h0B0B);
    bus_read(2'd2, v); check("R11 cap_hi", v, 16'h2222);
    bus_read(2'd0, v); check("R11 ctrl", v, 16'h0000);
  endtask

  task automatic t_setwins();
    logic [15:0] v;
    bus_write(2'd0, 16'h0001);
    cnt_val = 16'h0101; pin_lo = 1'b1; settle();
    pin_lo = 1'b0; settle();
    bus_read(2'd0, v); check("R10 pre-set", v & 16'h0040, 16'h0040);
    cnt_val = 16'h3C3C;
    pin_lo = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_write(2'd0, 16'h0001);
    bus_read(2'd0, v); check("R10 set wins", v & 16'h0040, 16'h0040);
    bus_read(2'd1, v); check("R10 capture", v, 16'h3C3C);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    pin_lo = 1'b0; pin_hi = 1'b0; cnt_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_both();
    t_off();
    t_capwr();
    t_setwins();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule